// File: doc/BRIEF.md
# Filtered Handshake Line Relay

This block carries two slow, critical control levels across a serial link. Each local control input is first brought into the crystal clock domain. It is then sampled at a very coarse rate divided from that clock, and the block accepts a new level only once an unbroken run of samples shows it. The filtered levels are the bits handed to the link transmitter. In the other direction, the two bits recovered from the link drive the local handshake outputs, but only while the link reports lock. Out of lock, both outputs sit High.

The sampling interval is `STD_DIV` crystal cycles in standard rate and twice that in double rate. Changing the rate select restarts the interval counter, so the new interval is counted from the cycle of the change. Link framing, line coding and the analogue front end belong to other blocks.

Top module: `hs_link_relay`

## Requirements
- R1: With `rate_dbl` = 0 the sample strobe fires once every `STD_DIV` cycles. The first strobe after reset release comes on the `STD_DIV`-th rising edge. A level applied just before the first edge therefore reaches `tx_bits` on exactly edge 4·`STD_DIV` (default depth 4).
- R2: With `rate_dbl` = 1 the sample interval is 2·`STD_DIV` cycles.
- R3: A new level on `ctl_in[i]` reaches `tx_bits[i]` only after `FILT_DEPTH` consecutive samples agree on it. Each input passes a two-flop synchroniser first. The delay is therefore at least (`FILT_DEPTH`−1)·interval+2 cycles and at most `FILT_DEPTH`·interval+1 cycles.
- R4: A level that lasts no more than (`FILT_DEPTH`−1)·interval cycles has no effect on `tx_bits`.
- R5: During and right after reset, `tx_bits` and `hs_out` are all ones (High).
- R6: While `locked` = 1, `hs_out[i]` equals `rx_bits[i]` one clock later.
- R7: While `locked` = 0, `hs_out` is all ones one clock later, whatever `rx_bits` holds.
- R8: A change of `rate_dbl` seen at edge k restarts the counter. Strobes then follow at k+L, k+2L, … where L is the new interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rate_dbl | input | 1 | 0 = standard interval, 1 = doubled interval |
| ctl_in | input | N_CH | Raw local control levels |
| locked | input | 1 | 1 when the link is locked |
| rx_bits | input | N_CH | Control bits recovered from the far end |
| tx_bits | output | N_CH | Filtered local levels, to the link |
| hs_out | output | N_CH | Handshake outputs |

## Verification
The bench runs with a small `STD_DIV`. It starts with a level applied at reset release, which pins the exact strobe phase in standard rate and tells an off-by-one in the divider or filter depth apart from a correct one. It then switches to double rate mid-period, together with an input change. The exact edge of the output change separates a counter that restarts from one that keeps its phase. It also shows a doubled interval apart from an unchanged one. A pulse one interval short of the filter length shows that short glitches are rejected. An unaligned change checked against both delay bounds shows the filter depth in standard mode. All four `rx_bits` patterns are applied with lock both off and on, to show the forcing and the pass-through.

// File: rtl/hs_relay_pkg.sv
package hs_relay_pkg;
  // sample-window state kept per channel
  typedef enum logic [1:0] {
    WIN_HOLD = 2'd0,
    WIN_ALL0 = 2'd1,
    WIN_ALL1 = 2'd2
  } win_t;

  function automatic win_t classify(input logic [31:0] v, input int unsigned n);
    logic a0, a1;
    a0 = 1'b1;
    a1 = 1'b1;
    for (int unsigned i = 0; i < n; i++) begin
      a0 &= ~v[i];
      a1 &= v[i];
    end
    if (a1) return WIN_ALL1;
    if (a0) return WIN_ALL0;
    return WIN_HOLD;
  endfunction
endpackage

// File: rtl/hs_sample_tick.sv
module hs_sample_tick #(
  parameter int unsigned STD_DIV = 18432
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_dbl,
  output logic tick
);
  localparam int unsigned DBL_DIV = 2 * STD_DIV;
  localparam int unsigned CW      = $clog2(DBL_DIV + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim_cur, lim_q;
  logic          rate_q, rate_chg;

  always_comb begin
    lim_cur  = rate_dbl ? CW'(DBL_DIV) : CW'(STD_DIV);
    lim_q    = rate_q   ? CW'(DBL_DIV) : CW'(STD_DIV);
    rate_chg = (rate_dbl != rate_q);
    tick     = !rate_chg && (cnt_q == lim_cur - CW'(1));
    if (rate_chg || tick) cnt_d = '0;
    else                  cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rate_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rate_q <= rate_dbl;
    end
  end

  // R1 R2: strobe is one cycle wide, counter stays below its limit
  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < lim_q);
  // R8: a rate change clears the counter
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rate_chg |=> (cnt_q == '0));
endmodule

// File: rtl/hs_input_filter.sv
module hs_input_filter #(
  parameter int unsigned FILT_DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw_in,
  output logic filt_out
);
  import hs_relay_pkg::*;

  logic                  sync1_q, sync2_q;
  logic [FILT_DEPTH-1:0] shr_q, shr_d;
  logic                  out_q, out_d;
  win_t                  win;

  always_comb begin
    if (FILT_DEPTH > 1) shr_d = {shr_q[FILT_DEPTH-2:0], sync2_q};
    else                shr_d = FILT_DEPTH'(sync2_q);
    win   = classify(32'(shr_d), FILT_DEPTH);
    out_d = out_q;
    if (tick) begin
      case (win)
        WIN_ALL1: out_d = 1'b1;
        WIN_ALL0: out_d = 1'b0;
        default:  out_d = out_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      shr_q   <= '1;
      out_q   <= 1'b1;
    end else begin
      sync1_q <= raw_in;
      sync2_q <= sync1_q;
      if (tick) shr_q <= shr_d;
      out_q <= out_d;
    end
  end

  assign filt_out = out_q;

  // R3: output moves only on a strobe and only to a unanimous window
  assert_move_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(out_q));
  assert_unanimous_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> (shr_q == {FILT_DEPTH{out_q}}));
endmodule

// File: rtl/hs_link_relay.sv
module hs_link_relay #(
  parameter int unsigned STD_DIV    = 18432,
  parameter int unsigned FILT_DEPTH = 4,
  parameter int unsigned N_CH       = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rate_dbl,
  input  logic [N_CH-1:0] ctl_in,
  input  logic            locked,
  input  logic [N_CH-1:0] rx_bits,
  output logic [N_CH-1:0] tx_bits,
  output logic [N_CH-1:0] hs_out
);
  logic            tick;
  logic [N_CH-1:0] hs_q, hs_d;
  logic            pv_q;

  hs_sample_tick #(.STD_DIV(STD_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .rate_dbl(rate_dbl), .tick(tick)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    hs_input_filter #(.FILT_DEPTH(FILT_DEPTH)) u_filt (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .raw_in(ctl_in[g]), .filt_out(tx_bits[g])
    );
  end

  always_comb begin
    hs_d = locked ? rx_bits : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= '1;
      pv_q <= 1'b0;
    end else begin
      hs_q <= hs_d;
      pv_q <= 1'b1;
    end
  end

  assign hs_out = hs_q;

  assert_unlocked_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && !$past(locked)) |-> (hs_out == '1));
  assert_locked_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_q && $past(locked)) |-> (hs_out == $past(rx_bits)));
  assert_reset_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pv_q |-> (hs_out == '1 && tx_bits == '1));
endmodule

// File: tb/hs_link_relay_test.sv
`timescale 1ns/1ps
module hs_link_relay_test;
  localparam int unsigned DIV = 8;
  localparam int unsigned LS  = DIV;
  localparam int unsigned LD  = 2 * DIV;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rate_dbl;
  logic [1:0] ctl_in;
  logic       locked;
  logic [1:0] rx_bits;
  logic [1:0] tx_bits;
  logic [1:0] hs_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hs_link_relay #(.STD_DIV(DIV), .FILT_DEPTH(4), .N_CH(2)) uut (
    .clk(clk), .rst_n(rst_n), .rate_dbl(rate_dbl), .ctl_in(ctl_in),
    .locked(locked), .rx_bits(rx_bits), .tx_bits(tx_bits), .hs_out(hs_out)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rate_dbl = 1'b0; ctl_in = 2'b11; locked = 1'b0; rx_bits = 2'b00;
    repeat (3) @(negedge clk);
    chk("R5 tx in reset", tx_bits, 2'b11);
    chk("R5 hs in reset", hs_out, 2'b11);
    rst_n = 1'b1;
    ctl_in = 2'b10;                       // ch0 goes Low before edge 1
    edges(4*LS - 1);
    chk("R1 before edge 4L", tx_bits, 2'b11);
    chk("R5 hs after release", hs_out, 2'b11);
    edges(1);
    chk("R1 at edge 4L", tx_bits, 2'b10);

    // R8 + R2: rate change and input change at the same edge k
    @(negedge clk);
    rate_dbl = 1'b1; ctl_in = 2'b11;
    edges(4*LD);                          // through edge k+4L-1
    chk("R8 R2 before k+4L", tx_bits, 2'b10);
    edges(1);
    chk("R8 R2 at k+4L", tx_bits, 2'b11);

    // R4: pulse of 3 intervals on ch1 (double rate) is rejected
    @(negedge clk);
    ctl_in = 2'b01;
    repeat (3*LD) @(posedge clk);
    @(negedge clk);
    ctl_in = 2'b11;
    edges(4*LD + 4);
    chk("R4 short pulse ignored", tx_bits, 2'b11);

    // R3: unaligned change in standard rate, check both bounds
    @(negedge clk);
    rate_dbl = 1'b0;
    repeat (5) @(negedge clk);
    ctl_in = 2'b01;
    edges(3*LS + 1);
    chk("R3 not before lower bound", tx_bits, 2'b11);
    edges(LS + 1);
    chk("R3 by upper bound", tx_bits, 2'b01);

    // R7: unlocked forces High for every rx pattern
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      locked = 1'b0; rx_bits = 2'(p);
      edges(1);
      chk($sformatf("R7 unlocked rx=%0d", p), hs_out, 2'b11);
    end
    // R6: locked passes rx through after one clock
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      locked = 1'b1; rx_bits = 2'(3 - p);
      edges(1);
      chk($sformatf("R6 locked rx=%0d", 3 - p), hs_out, 2'(3 - p));
    end
    @(negedge clk);
    locked = 1'b0;
    edges(1);
    chk("R7 lock lost", hs_out, 2'b11);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule